// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel that runs a chain of descriptors held in memory. Software writes the descriptors, then pulses `start` with the address of the first one. The channel reads four 32-bit words per descriptor over a simple memory master port and decodes them. It then does one of three things: it copies a counted run of units from a source to a destination, it waits until an external event vector matches a masked value, or it writes one 32-bit constant to an address. When the descriptor is complete, the channel loads the next descriptor from an absolute address or from a signed jump counted in descriptors, or it goes back to idle.

A data copy is paced by a peripheral request. In block mode each request moves one block. In whole mode one request starts the copy and the copy runs to the end of its count. A loop counter, loaded at start, lets a descriptor jump back a set number of times and then fall through to the next descriptor in memory. This gives looped sequences, rings and ping-pong buffers without help from the CPU. A stop request or a disabled request gate halts the channel at a clean unit boundary. A fetch error or an illegal descriptor sets an error flag and halts the channel.

Top module: `chain_dma`

## Requirements
- R1: After reset `busy`, `done`, `err` and `mem_req` are low and `remain` is zero.
- R2: Descriptor word 0 is the control word. Bits [1:0] are the kind: 0 copy, 1 wait, 2 constant write; 3 is illegal. Bits [31:16] are the count field. A copy with count field N moves exactly N+1 units and touches no memory beyond them.
- R3: The unit size is in control bits [6:5]: 0 byte, 1 half-word, 2 word. The source step is in bits [8:7] and the destination step in bits [11:10]: 0 one unit, 1 two units, 2 four units, 3 no step. Bit 9 is the source sign and bit 12 the destination sign; a sign of 1 means the address goes down. Each unit is taken from its byte lane of the source word and written to its byte lane of the destination word.
- R4: A constant write stores descriptor word 1 as a full word at the address in descriptor word 2.
- R5: A wait descriptor holds the channel until `(sync_in ^ w1[15:8]) & w1[7:0]` is zero. Inputs outside the mask have no effect.
- R6: Link word 3 controls what happens next. Bit 0 enables the link. If bit 1 is 0, bits [31:2] give the absolute word address of the next descriptor. If bit 1 is 1, bits [31:2] are a signed descriptor jump: the next address is the current address plus 16 bytes times the jump. With bit 0 clear the channel returns to idle. `done` pulses for one cycle at the end of a descriptor only when control bit 2 is set.
- R7: A ring of two descriptors, the first with jump +1 and the second with jump -1, fills the two buffers alternately for as long as requests arrive.
- R8: Control bit 4 enables the loop counter. If the counter is nonzero, the channel decrements it and follows the link. If the counter is zero, the channel continues at the current descriptor address plus 16.
- R9: If control bit 3 is set (block mode), each accepted request moves 2^b units, where b is control bits [15:13]. `remain` reports the units left in the current descriptor only.
- R10: While `req_en` is low, no new block and no new whole copy starts.
- R11: A `stop` pulse lets the unit in flight finish and then halts the channel. `busy` falls and `remain` keeps the count that was not moved.
- R12: A fetch with `mem_err`, a misaligned start address, an illegal kind or size, or a copy or constant address misaligned for its unit size sets `err` and halts the channel. The next `start` clears `err`.
- R13: `mem_req` stays high with a stable address until `mem_ack`. It is low whenever the channel is idle. A write enables one, two or four byte lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted when idle |
| start_addr | input | 32 | Byte address of the first descriptor |
| loop_init | input | LOOP_W | Loop counter value loaded at start |
| stop | input | 1 | Stop request pulse |
| req_en | input | 1 | Gate for the peripheral request |
| periph_req | input | 1 | Peripheral request level |
| sync_in | input | SYNC_W | Event vector for wait descriptors |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_ack | input | 1 | Memory access complete |
| mem_err | input | 1 | Memory access error, valid with ack |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle descriptor completion pulse |
| err | output | 1 | Sticky error flag |
| remain | output | CNT_W+1 | Units left in the current descriptor |

## Verification
Assertions check the properties that must hold on every cycle. These are: the request holds its address until it is acknowledged, the port is quiet when idle, `done` is a single pulse, an error coincides with idle, `remain` counts down exactly once per completed unit, and no access starts while the request gate is closed. Other behaviours only show up in bench scenarios that compare final memory contents against a bench model. These include lane placement under every combination of size, step and sign, ring alternation, loop counts with fall-through, masked wait release, and where a stop leaves the copy.

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int CNT_W  = 16,
  parameter int SYNC_W = 8,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       start_addr,
  input  logic [LOOP_W-1:0] loop_init,
  input  logic              stop,
  input  logic              req_en,
  input  logic              periph_req,
  input  logic [SYNC_W-1:0] sync_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [CNT_W:0]    remain
);

  typedef enum logic [3:0] {S_IDLE, S_FETCH, S_DEC, S_WAIT, S_RD, S_WR, S_SYNC, S_IMM, S_FIN} st_t;

  st_t               st;
  logic [31:0]       dsc [4];
  logic [1:0]        fidx;
  logic [31:0]       cur, src, dst, unit;
  logic [CNT_W:0]    left;
  logic [7:0]        blk;
  logic [LOOP_W-1:0] loopc;
  logic              stop_pend, err_q;

  wire [1:0]       kind  = dsc[0][1:0];
  wire             dn    = dsc[0][2];
  wire             bmode = dsc[0][3];
  wire             decl  = dsc[0][4];
  wire [1:0]       usz   = dsc[0][6:5];
  wire [1:0]       sstep = dsc[0][8:7];
  wire             sneg  = dsc[0][9];
  wire [1:0]       dstep = dsc[0][11:10];
  wire             dneg  = dsc[0][12];
  wire [2:0]       bsz   = dsc[0][15:13];
  wire [CNT_W-1:0] cntf  = dsc[0][31 -: CNT_W];

  wire [31:0] ub  = 32'd1 << usz;
  wire [31:0] sd  = (sstep == 2'd3) ? 32'd0 : (ub << sstep);
  wire [31:0] dd  = (dstep == 2'd3) ? 32'd0 : (ub << dstep);
  wire [31:0] jmp = {{2{dsc[3][31]}}, dsc[3][31:2]};
  wire [31:0] tgt = dsc[3][1] ? cur + (jmp << 4) : {dsc[3][31:2], 2'b00};

  wire mis_s = (usz == 2'd1 && dsc[1][0]) || (usz == 2'd2 && dsc[1][1:0] != 2'b00);
  wire mis_d = (usz == 2'd1 && dsc[2][0]) || (usz == 2'd2 && dsc[2][1:0] != 2'b00);
  wire bad   = (kind == 2'd3) ||
               (kind == 2'd0 && (usz == 2'd3 || mis_s || mis_d)) ||
               (kind == 2'd2 && dsc[2][1:0] != 2'b00);
  wire match = ((sync_in ^ dsc[1][2*SYNC_W-1:SYNC_W]) & dsc[1][SYNC_W-1:0]) == '0;

  assign busy   = (st != S_IDLE);
  assign done   = (st == S_FIN) && dn;
  assign err    = err_q;
  assign remain = left;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = 32'd0;
    mem_wdata = 32'd0;
    mem_be    = 4'd0;
    case (st)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur + {28'd0, fidx, 2'b00};
      end
      S_RD: begin
        mem_req  = 1'b1;
        mem_addr = {src[31:2], 2'b00};
      end
      S_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {dst[31:2], 2'b00};
        case (usz)
          2'd0:    begin mem_wdata = {4{unit[7:0]}};  mem_be = 4'b0001 << dst[1:0]; end
          2'd1:    begin mem_wdata = {2{unit[15:0]}}; mem_be = 4'b0011 << dst[1:0]; end
          default: begin mem_wdata = unit;            mem_be = 4'b1111; end
        endcase
      end
      S_IMM: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst;
        mem_wdata = dsc[1];
        mem_be    = 4'b1111;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      for (int i = 0; i < 4; i++) dsc[i] <= 32'd0;
      fidx <= 2'd0; cur <= 32'd0; src <= 32'd0; dst <= 32'd0; unit <= 32'd0;
      left <= '0; blk <= 8'd0; loopc <= '0; stop_pend <= 1'b0; err_q <= 1'b0;
    end else begin
      if (stop && st != S_IDLE) stop_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          stop_pend <= 1'b0;
          if (start) begin
            err_q <= 1'b0;
            loopc <= loop_init;
            cur   <= start_addr;
            fidx  <= 2'd0;
            left  <= '0;
            if (start_addr[1:0] != 2'b00) err_q <= 1'b1;
            else st <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin err_q <= 1'b1; st <= S_IDLE; end
          else begin
            dsc[fidx] <= mem_rdata;
            fidx <= fidx + 2'd1;
            if (fidx == 2'd3) st <= S_DEC;
          end
        end
        S_DEC: begin
          src  <= dsc[1];
          dst  <= dsc[2];
          left <= (kind == 2'd0) ? {1'b0, cntf} + 1'b1 : '0;
          if (bad) begin err_q <= 1'b1; st <= S_IDLE; end
          else case (kind)
            2'd0:    st <= S_WAIT;
            2'd1:    st <= S_SYNC;
            default: st <= S_IMM;
          endcase
        end
        S_WAIT: begin
          if (stop_pend) st <= S_IDLE;
          else if (periph_req && req_en) begin
            blk <= 8'd1 << bsz;
            st  <= S_RD;
          end
        end
        S_RD: if (mem_ack) begin
          if (mem_err) begin err_q <= 1'b1; st <= S_IDLE; end
          else begin
            unit <= mem_rdata >> {src[1:0], 3'b000};
            st   <= S_WR;
          end
        end
        S_WR: if (mem_ack) begin
          if (mem_err) begin err_q <= 1'b1; st <= S_IDLE; end
          else begin
            src  <= sneg ? src - sd : src + sd;
            dst  <= dneg ? dst - dd : dst + dd;
            left <= left - 1'b1;
            blk  <= blk - 8'd1;
            if (left == 1) st <= S_FIN;
            else if (stop_pend || stop) st <= S_IDLE;
            else if (bmode && blk == 8'd1) st <= S_WAIT;
            else st <= S_RD;
          end
        end
        S_SYNC: begin
          if (stop_pend) st <= S_IDLE;
          else if (match) st <= S_FIN;
        end
        S_IMM: if (mem_ack) begin
          if (mem_err) begin err_q <= 1'b1; st <= S_IDLE; end
          else st <= S_FIN;
        end
        S_FIN: begin
          fidx <= 2'd0;
          if (stop_pend) st <= S_IDLE;
          else if (decl) begin
            st <= S_FETCH;
            if (loopc != '0) begin
              loopc <= loopc - 1'b1;
              cur   <= tgt;
            end else cur <= cur + 32'd16;
          end else if (dsc[3][0]) begin
            st  <= S_FETCH;
            cur <= tgt;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_req); // R13
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4)); // R3
  AST_ERR_HALT: assert property (@(posedge clk) disable iff (rst) $rose(err) |-> !busy); // R12
  AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == S_WR && mem_ack && !mem_err) |=> remain == $past(remain) - {{CNT_W{1'b0}}, 1'b1}); // R9
  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && !(periph_req && req_en)) |=> !mem_req); // R10

endmodule

// File: tb/sim_chain_dma.sv
`timescale 1ns/1ps
module sim_chain_dma;
  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, stop = 0, req_en = 1, periph_req = 0;
  logic [31:0] start_addr = 0;
  logic [7:0] loop_init = 0, sync_in = 0;
  logic mem_req, mem_we, mem_ack, mem_err, busy, done, err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [16:0] remain;

  logic [31:0] mem  [0:255];
  logic [31:0] refm [0:255];
  int errors = 0, checks = 0, dcount = 0;

  always #2 clk = ~clk;

  chain_dma u0 (.clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .loop_init(loop_init),
    .stop(stop), .req_en(req_en), .periph_req(periph_req), .sync_in(sync_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .err(err), .remain(remain));

  assign mem_ack   = mem_req;
  assign mem_err   = |mem_addr[31:10];
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_we && !mem_err)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (!rst && done) dcount <= dcount + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input logic [1:0] k, input logic dn, input logic bm, input logic dl,
      input logic [1:0] sz, input logic [1:0] ss, input logic sn, input logic [1:0] ds, input logic dg,
      input logic [2:0] bs, input logic [15:0] cnt);
    return {cnt, bs, dg, ds, sn, ss, sz, dl, bm, dn, k};
  endfunction

  function automatic logic [7:0] mb(input logic [31:0] a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] w0, w1, w2, w3);
    mem[a[9:2]] = w0; mem[a[9:2]+1] = w1; mem[a[9:2]+2] = w2; mem[a[9:2]+3] = w3;
  endtask

  task automatic run(input logic [31:0] a, input logic [7:0] lp);
    start_addr = a; loop_init = lp; start = 1;
    tick(1);
    start = 0;
    for (int i = 0; i < 4000 && busy; i++) tick(1);
  endtask

  task automatic wait_dn(input int target);
    for (int i = 0; i < 4000 && dcount < target; i++) tick(1);
  endtask

  task automatic model_move(input logic [31:0] c, input logic [31:0] s0, input logic [31:0] d0);
    logic [31:0] s, d, ubt, sdl, ddl;
    s = s0; d = d0;
    ubt = 32'd1 << c[6:5];
    sdl = (c[8:7] == 2'd3) ? 0 : ubt << c[8:7];
    ddl = (c[11:10] == 2'd3) ? 0 : ubt << c[11:10];
    for (int u = 0; u <= int'(c[31:16]); u++) begin
      for (int k = 0; k < int'(ubt); k++) begin
        logic [31:0] sa, da;
        sa = s + k; da = d + k;
        refm[da[9:2]][8*da[1:0] +: 8] = refm[sa[9:2]][8*sa[1:0] +: 8];
      end
      s = c[9] ? s - sdl : s + sdl;
      d = c[12] ? d - ddl : d + ddl;
    end
  endtask

  task automatic clear_dst;
    for (int i = 128; i < 256; i++) mem[i] = 32'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d0, bad, wr, r;
    logic [31:0] c, so, dof;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    for (int i = 0; i < 64; i++) mem[64+i] = 32'h10000001 + i * 32'h01010101;
    tick(4);
    rst = 0;
    tick(1);
    chk(!busy && !done && !err && !mem_req && remain == 0, "R1 reset state", {busy, done, err, mem_req}, 0);

    // R2 word copy, count field 3
    put(32'h00, ctl(0,1,0,0,2,0,0,0,0,0,3), 32'h100, 32'h200, 32'h0);
    periph_req = 1; d0 = dcount;
    run(32'h00, 0);
    bad = 0;
    for (int i = 0; i < 4; i++) if (mem[128+i] != mem[64+i]) bad++;
    chk(bad == 0, "R2 four words copied", bad, 0);
    chk(mem[132] == 0, "R2 no fifth unit", mem[132], 0);
    chk(dcount - d0 == 1 && !busy, "R6 single done, idle without link", dcount - d0, 1);

    // R6 absolute chain, done only from last
    put(32'h10, ctl(0,0,0,0,0,0,0,0,0,0,1), 32'h100, 32'h220, 32'h21);
    put(32'h20, ctl(0,1,0,0,1,0,0,0,0,0,1), 32'h104, 32'h228, 32'h0);
    d0 = dcount;
    run(32'h10, 0);
    chk(mem[136][15:0] == mem[64][15:0] && mem[136][31:16] == 0, "R6 first link bytes", mem[136], mem[64][15:0]);
    chk(mem[138] == mem[65], "R6 second link halves", mem[138], mem[65]);
    chk(dcount - d0 == 1, "R6 done only when bit set", dcount - d0, 1);

    // R3 random copies against bench model
    for (int t = 0; t < 24; t++) begin
      logic [1:0] sz;
      clear_dst;
      sz = 2'($urandom_range(0, 2));
      c = ctl(0, 1, 0, 0, sz, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 0, 16'($urandom_range(0, 7)));
      so  = 32'h180 + ($urandom_range(0, 3) & (32'd3 >> sz) & ~((32'd1 << sz) - 1));
      dof = 32'h300 + ($urandom_range(0, 3) & (32'd3 >> sz) & ~((32'd1 << sz) - 1));
      put(32'hE0, c, so, dof, 32'h0);
      for (int i = 0; i < 256; i++) refm[i] = mem[i];
      model_move(c, so, dof);
      d0 = dcount;
      run(32'hE0, 0);
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] != refm[i]) bad++;
      chk(bad == 0 && dcount - d0 == 1 && !err, $sformatf("R3 random copy %0d", t), bad, 0);
    end

    // R8 loop counter with relative jump 0, then fall through to constant write (R4)
    clear_dst;
    put(32'h40, ctl(0,1,0,1,2,0,0,0,0,0,0), 32'h100, 32'h200, 32'h3);
    put(32'h50, ctl(2,1,0,0,0,0,0,0,0,0,0), 32'hCAFEF00D, 32'h210, 32'h0);
    d0 = dcount;
    run(32'h40, 2);
    chk(dcount - d0 == 4, "R8 three passes then fall through", dcount - d0, 4);
    chk(mem[132] == 32'hCAFEF00D, "R4 constant written", mem[132], 32'hCAFEF00D);
    d0 = dcount;
    run(32'h40, 0);
    chk(dcount - d0 == 2, "R8 zero loop falls through at once", dcount - d0, 2);

    // R5 masked wait
    put(32'h60, ctl(1,0,0,0,0,0,0,0,0,0,0), {16'd0, 8'hA5, 8'h0F}, 32'h0, 32'h71);
    put(32'h70, ctl(2,1,0,0,0,0,0,0,0,0,0), 32'h12345678, 32'h214, 32'h0);
    sync_in = 8'h50;
    start_addr = 32'h60; start = 1; tick(1); start = 0;
    tick(30);
    chk(busy && mem[133] == 0, "R5 holds while masked bits differ", mem[133], 0);
    sync_in = 8'hF5;
    for (int i = 0; i < 100 && busy; i++) tick(1);
    chk(mem[133] == 32'h12345678, "R5 released on masked match", mem[133], 32'h12345678);

    // R7 relative ping-pong ring, block mode one byte per request
    clear_dst;
    put(32'h80, ctl(0,1,1,0,0,0,0,0,0,0,4), 32'h100, 32'h240, 32'h7);
    put(32'h90, ctl(0,1,1,0,0,0,0,0,0,0,4), 32'h108, 32'h248, 32'hFFFFFFFF);
    d0 = dcount; periph_req = 1;
    start_addr = 32'h80; start = 1; tick(1); start = 0;
    wait_dn(d0 + 2);
    periph_req = 0;
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      if (mb(32'h240 + k) != mb(32'h100 + k)) bad++;
      if (mb(32'h248 + k) != mb(32'h108 + k)) bad++;
    end
    chk(bad == 0, "R7 both buffers filled", bad, 0);
    tick(10);
    mem[144] = 0; mem[145] = 0; mem[146] = 0; mem[147] = 0;
    periph_req = 1;
    wait_dn(d0 + 3);
    periph_req = 0;
    tick(10);
    bad = 0;
    for (int k = 0; k < 5; k++) if (mb(32'h240 + k) != mb(32'h100 + k)) bad++;
    chk(bad == 0 && mem[146] == 0 && mem[147] == 0, "R7 ring returns to first buffer", bad, 0);
    stop = 1; tick(1); stop = 0; tick(3);
    chk(!busy, "R11 stop while waiting", busy, 0);

    // R10 and R9: gate closed, then single request pulse moves one block
    clear_dst;
    put(32'hA0, ctl(0,1,1,0,0,0,0,0,0,1,7), 32'h100, 32'h260, 32'h0);
    req_en = 0; periph_req = 1;
    start_addr = 32'hA0; start = 1; tick(1); start = 0;
    tick(30);
    chk(remain == 8 && mem[152] == 0 && busy, "R10 no progress with gate low", remain, 8);
    periph_req = 0; req_en = 1; tick(3);
    periph_req = 1; tick(1); periph_req = 0;
    tick(20);
    chk(remain == 6, "R9 one block per request", remain, 6);
    chk(mem[152][15:0] == mem[64][15:0] && mem[152][31:16] == 0, "R9 block of two bytes", mem[152], mem[64][15:0]);
    periph_req = 1;
    for (int i = 0; i < 400 && busy; i++) tick(1);
    chk(mem[152] == mem[64] && mem[153] == mem[65] && remain == 0, "R9 remaining blocks", mem[153], mem[65]);

    // R11 stop in the middle of a long copy
    clear_dst;
    put(32'hB0, ctl(0,1,0,0,2,0,0,0,0,0,63), 32'h100, 32'h300, 32'h0);
    start_addr = 32'hB0; start = 1; tick(1); start = 0;
    tick(20);
    stop = 1; tick(1); stop = 0;
    tick(3);
    r = int'(remain); wr = 64 - r;
    chk(!busy && r > 0 && r < 64, "R11 halts with units left", remain, 0);
    bad = 0;
    for (int i = 0; i < 64; i++) if (mem[192+i] != ((i < wr) ? mem[64+i] : 32'd0)) bad++;
    chk(bad == 0, "R11 written count matches remain", bad, 0);

    // R12 errors
    put(32'hC0, ctl(0,1,0,0,2,0,0,0,0,0,0), 32'h102, 32'h200, 32'h0);
    run(32'hC0, 0);
    chk(err && !busy && mem[128] == 0, "R12 misaligned word source", err, 1);
    put(32'hD0, ctl(2,1,0,0,0,0,0,0,0,0,0), 32'hDEADBEEF, 32'h21C, 32'h0);
    run(32'hD0, 0);
    chk(!err && mem[135] == 32'hDEADBEEF, "R12 start clears error", err, 0);
    run(32'h1000, 0);
    chk(err && !busy, "R12 fetch error", err, 1);
    run(32'h42, 0);
    chk(err && !busy, "R12 misaligned start", err, 1);
    put(32'hC0, 32'h3, 32'h0, 32'h0, 32'h0);
    run(32'hC0, 0);
    chk(err && !busy, "R12 illegal kind", err, 1);
    chk(!mem_req, "R13 port quiet when idle", mem_req, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule